// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block is the per-channel register bank of a descriptor-driven DMA controller. A processor reaches it through a simple 32-bit memory-mapped request port. Each channel owns an 8 KiB address window. Inside that window, a small set of word registers holds the descriptor pointers, the configuration, the command and stream-command words, and the interrupt mask. The block also keeps the channel's run state (reset, stopped or running) and builds the status word from live values whenever it is read.

The transfer engines sit beside the bank. They receive requests from it as single-cycle pulses: load a data descriptor, start, load a context descriptor, and continue. They report back through per-channel inputs: an end-of-list flag, a stream-source field, and per-bit interrupt set pulses. Each channel drives one level interrupt line, which is high while any raw interrupt bit is both set and enabled in the mask.

Read data is registered and appears one cycle after the request. Only full-word accesses are honoured.

Top module: `dma_chan_regs`

## Requirements
- R1: The channel number is address bits [ADDR_W-1:13] and the word index is address bits [7:2]. A channel number of NUM_CH or higher reads zero, and writes to it change nothing.
- R2: The data pointer (0x00), saved descriptor pointer (0x58), saved buffer pointer (0x5C), group pointer (0x60), group-down pointer (0x7C) and command (0x80) store and return all 32 bits. Config (0x84) keeps bits [1:0]. Stream command (0x9C) keeps bits [9:0]. Mask (0x8C) keeps bits [INTR_W-1:0].
- R3: The run state is 1 for reset, 2 for stopped and 4 for running, and it is reset after reset. A config write with bit 1 set moves it to stopped. A config write with bit 0 clear moves it to reset, and this takes priority over bit 1. A start request moves it to running.
- R4: Status (0x88) returns the run state in bits [2:0], the live end-of-list input in bit 5 and the live stream-source input from bit 8 upward. With a source of 1 after reset, it reads 0x101. Writes to status are ignored.
- R5: Raw interrupt (0x94) bits are set by the intr_set_i pulses and cleared by writing ones to acknowledge (0x90). When a set and an acknowledge of the same bit fall in the same cycle, the bit stays set. Acknowledge reads zero, and writes to raw are ignored.
- R6: Masked interrupt (0x98) reads raw AND mask, and irq_o of the channel is the OR of that value.
- R7: A stream-command write pulses ld_data_o when any bit of 0x140 is set. It also pulses start_o when bit 0x20 is set alongside. It pulses ld_ctx_o when bit 0x200 is set. Each pulse is high for exactly the cycle after the write.
- R8: A command write pulses cont_o of that channel for the cycle after the write.
- R9: A write whose byte enables are not all ones changes nothing and raises no pulse. Such a read returns zero. Writes to undefined word indices change nothing, and reads of them return zero.
- R10: Read data is valid on rdata_o in the cycle after the read request, and rdata_o is zero in any cycle that does not follow a full-word read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_be_i | input | 4 | Byte enables |
| req_wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the request |
| eol_i | input | NUM_CH | End-of-list flag per channel |
| src_i | input | NUM_CH*SRC_W | Stream-source field per channel |
| intr_set_i | input | NUM_CH*INTR_W | Raw interrupt set pulses per channel |
| irq_o | output | NUM_CH | Level interrupt per channel |
| ld_data_o | output | NUM_CH | Data-descriptor load pulse |
| start_o | output | NUM_CH | Channel start pulse |
| ld_ctx_o | output | NUM_CH | Context-descriptor load pulse |
| cont_o | output | NUM_CH | Continue pulse |

## Verification
The bench uses the defaults: NUM_CH=3, ADDR_W=16, INTR_W=4 and SRC_W=4. With three channels, the 16-bit address can still name channels 3 to 7. This lets the bench aim accesses outside the populated range, and it lets it check that one channel's writes never reach another. A 4-bit interrupt field and a partial mask allow raw and masked values to differ, so the bench can watch the interrupt line while individual bits are acknowledged. Each channel gets a different source value, so the status word shows which channel answered.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

    typedef enum logic [2:0] {
        ST_RESET   = 3'd1,
        ST_STOPPED = 3'd2,
        ST_RUNNING = 3'd4
    } ch_state_e;

    localparam int WIN_SHIFT = 13;
    localparam int IDX_W     = 6;

    localparam logic [IDX_W-1:0] RI_DATA   = 6'h00;
    localparam logic [IDX_W-1:0] RI_SDESC  = 6'h16;
    localparam logic [IDX_W-1:0] RI_SBUF   = 6'h17;
    localparam logic [IDX_W-1:0] RI_GROUP  = 6'h18;
    localparam logic [IDX_W-1:0] RI_GDOWN  = 6'h1F;
    localparam logic [IDX_W-1:0] RI_CMD    = 6'h20;
    localparam logic [IDX_W-1:0] RI_CFG    = 6'h21;
    localparam logic [IDX_W-1:0] RI_STAT   = 6'h22;
    localparam logic [IDX_W-1:0] RI_MASK   = 6'h23;
    localparam logic [IDX_W-1:0] RI_ACK    = 6'h24;
    localparam logic [IDX_W-1:0] RI_RAW    = 6'h25;
    localparam logic [IDX_W-1:0] RI_MASKED = 6'h26;
    localparam logic [IDX_W-1:0] RI_STREAM = 6'h27;

    localparam int           SC_W         = 10;
    localparam logic [SC_W-1:0] SC_LOAD_DATA = 10'h140;
    localparam logic [SC_W-1:0] SC_BURST     = 10'h020;
    localparam logic [SC_W-1:0] SC_LOAD_CTX  = 10'h200;

endpackage

// File: rtl/dcr_decode.sv
module dcr_decode #(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 16
) (
    input  logic                          valid,
    input  logic                          write,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [3:0]                    be,
    output logic [dcr_pkg::IDX_W-1:0]     reg_idx,
    output logic [ADDR_W-dcr_pkg::WIN_SHIFT-1:0] chan,
    output logic [NUM_CH-1:0]             wr_sel,
    output logic                          rd_hit
);
    import dcr_pkg::*;

    localparam int CHF_W = ADDR_W - WIN_SHIFT;

    logic full_word;
    logic in_range;
    logic unused_addr;

    assign unused_addr = ^{addr[WIN_SHIFT-1:8], addr[1:0]};
    assign full_word   = (be == 4'hF);
    assign chan        = addr[ADDR_W-1:WIN_SHIFT];
    assign in_range    = (32'(chan) < NUM_CH);
    assign reg_idx     = addr[7:2];
    assign rd_hit      = valid && !write && full_word && in_range;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
        assign wr_sel[i] = valid && write && full_word && (chan == CHF_W'(i));
    end

endmodule

// File: rtl/dcr_channel.sv
module dcr_channel #(
    parameter int INTR_W = 4,
    parameter int SRC_W  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [dcr_pkg::IDX_W-1:0]  reg_idx,
    input  logic [31:0]                wdata,
    input  logic [INTR_W-1:0]          intr_set,
    input  logic                       eol,
    input  logic [SRC_W-1:0]           src,
    output logic [31:0]                rd_word,
    output logic                       irq,
    output logic                       ld_data,
    output logic                       start,
    output logic                       ld_ctx,
    output logic                       cont
);
    import dcr_pkg::*;

    typedef struct packed {
        logic [31:0]       data;
        logic [31:0]       sdesc;
        logic [31:0]       sbuf;
        logic [31:0]       group;
        logic [31:0]       gdown;
        logic [31:0]       cmd;
        logic [1:0]        cfg;
        logic [INTR_W-1:0] mask;
        logic [INTR_W-1:0] raw;
        logic [SC_W-1:0]   stream;
        ch_state_e         state;
        logic              ld_data;
        logic              start;
        logic              ld_ctx;
        logic              cont;
    } chan_s;

    chan_s ch_d, ch_q;

    always_comb begin
        logic [INTR_W-1:0] ack;
        logic [SC_W-1:0]   sc;
        ch_d         = ch_q;
        ch_d.ld_data = 1'b0;
        ch_d.start   = 1'b0;
        ch_d.ld_ctx  = 1'b0;
        ch_d.cont    = 1'b0;
        ack          = '0;
        sc           = wdata[SC_W-1:0];
        if (wr_en) begin
            case (reg_idx)
                RI_DATA:  ch_d.data  = wdata;
                RI_SDESC: ch_d.sdesc = wdata;
                RI_SBUF:  ch_d.sbuf  = wdata;
                RI_GROUP: ch_d.group = wdata;
                RI_GDOWN: ch_d.gdown = wdata;
                RI_CMD: begin
                    ch_d.cmd  = wdata;
                    ch_d.cont = 1'b1;
                end
                RI_CFG: begin
                    ch_d.cfg = wdata[1:0];
                    if (wdata[1]) ch_d.state = ST_STOPPED;
                    if (!wdata[0]) ch_d.state = ST_RESET;
                end
                RI_MASK: ch_d.mask = wdata[INTR_W-1:0];
                RI_ACK:  ack       = wdata[INTR_W-1:0];
                RI_STREAM: begin
                    ch_d.stream = sc;
                    if ((sc & SC_LOAD_DATA) != '0) begin
                        ch_d.ld_data = 1'b1;
                        if ((sc & SC_BURST) != '0) begin
                            ch_d.start = 1'b1;
                            ch_d.state = ST_RUNNING;
                        end
                    end
                    if ((sc & SC_LOAD_CTX) != '0) ch_d.ld_ctx = 1'b1;
                end
                default: ;
            endcase
        end
        ch_d.raw = (ch_q.raw & ~ack) | intr_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q       <= '0;
            ch_q.state <= ST_RESET;
        end else begin
            ch_q <= ch_d;
        end
    end

    always_comb begin
        logic [31:0] stat;
        stat              = '0;
        stat[2:0]         = ch_q.state;
        stat[5]           = eol;
        stat[8 +: SRC_W]  = src;
        case (reg_idx)
            RI_DATA:   rd_word = ch_q.data;
            RI_SDESC:  rd_word = ch_q.sdesc;
            RI_SBUF:   rd_word = ch_q.sbuf;
            RI_GROUP:  rd_word = ch_q.group;
            RI_GDOWN:  rd_word = ch_q.gdown;
            RI_CMD:    rd_word = ch_q.cmd;
            RI_CFG:    rd_word = 32'(ch_q.cfg);
            RI_STAT:   rd_word = stat;
            RI_MASK:   rd_word = 32'(ch_q.mask);
            RI_RAW:    rd_word = 32'(ch_q.raw);
            RI_MASKED: rd_word = 32'(ch_q.raw & ch_q.mask);
            RI_STREAM: rd_word = 32'(ch_q.stream);
            default:   rd_word = '0;
        endcase
    end

    assign irq     = |(ch_q.raw & ch_q.mask);
    assign ld_data = ch_q.ld_data;
    assign start   = ch_q.start;
    assign ld_ctx  = ch_q.ld_ctx;
    assign cont    = ch_q.cont;

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 16,
    parameter int INTR_W = 4,
    parameter int SRC_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid_i,
    input  logic                     req_write_i,
    input  logic [ADDR_W-1:0]        req_addr_i,
    input  logic [3:0]               req_be_i,
    input  logic [31:0]              req_wdata_i,
    output logic [31:0]              rdata_o,
    input  logic [NUM_CH-1:0]        eol_i,
    input  logic [NUM_CH*SRC_W-1:0]  src_i,
    input  logic [NUM_CH*INTR_W-1:0] intr_set_i,
    output logic [NUM_CH-1:0]        irq_o,
    output logic [NUM_CH-1:0]        ld_data_o,
    output logic [NUM_CH-1:0]        start_o,
    output logic [NUM_CH-1:0]        ld_ctx_o,
    output logic [NUM_CH-1:0]        cont_o
);
    import dcr_pkg::*;

    localparam int CHF_W = ADDR_W - WIN_SHIFT;

    typedef struct packed {
        logic [31:0] rdata;
    } top_s;

    logic [IDX_W-1:0]  reg_idx;
    logic [CHF_W-1:0]  chan;
    logic [NUM_CH-1:0] wr_sel;
    logic              rd_hit;
    logic [31:0]       ch_rd [NUM_CH];
    top_s              top_d, top_q;

    dcr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .valid   (req_valid_i),
        .write   (req_write_i),
        .addr    (req_addr_i),
        .be      (req_be_i),
        .reg_idx (reg_idx),
        .chan    (chan),
        .wr_sel  (wr_sel),
        .rd_hit  (rd_hit)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dcr_channel #(.INTR_W(INTR_W), .SRC_W(SRC_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_sel[c]),
            .reg_idx  (reg_idx),
            .wdata    (req_wdata_i),
            .intr_set (intr_set_i[c*INTR_W +: INTR_W]),
            .eol      (eol_i[c]),
            .src      (src_i[c*SRC_W +: SRC_W]),
            .rd_word  (ch_rd[c]),
            .irq      (irq_o[c]),
            .ld_data  (ld_data_o[c]),
            .start    (start_o[c]),
            .ld_ctx   (ld_ctx_o[c]),
            .cont     (cont_o[c])
        );
    end

    always_comb begin
        top_d.rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_hit && (chan == CHF_W'(i))) top_d.rdata = ch_rd[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign rdata_o = top_q.rdata;

endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
    parameter int NUM_CH = 3,
    parameter int INTR_W = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid_i,
    input logic                     req_write_i,
    input logic [3:0]               req_be_i,
    input logic [31:0]              rdata_o,
    input logic [NUM_CH*INTR_W-1:0] intr_set_i,
    input logic [NUM_CH-1:0]        irq_o,
    input logic [NUM_CH-1:0]        ld_data_o,
    input logic [NUM_CH-1:0]        start_o,
    input logic [NUM_CH-1:0]        ld_ctx_o,
    input logic [NUM_CH-1:0]        cont_o
);
    logic full_wr, full_rd;
    assign full_wr = req_valid_i && req_write_i && (req_be_i == 4'hF);
    assign full_rd = req_valid_i && !req_write_i && (req_be_i == 4'hF);

    p_rdata_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(full_rd) |-> (rdata_o == 32'd0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        p_cont_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
            cont_o[c] |-> $past(full_wr));
        p_start_with_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
            start_o[c] |-> ld_data_o[c]);
        p_ctx_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ld_ctx_o[c] |-> $past(full_wr));
        p_irq_rise_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_o[c]) |-> $past((intr_set_i[c*INTR_W +: INTR_W] != '0) || full_wr));
    end

endmodule

bind dma_chan_regs dma_chan_regs_chk #(.NUM_CH(NUM_CH), .INTR_W(INTR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_be_i    (req_be_i),
    .rdata_o     (rdata_o),
    .intr_set_i  (intr_set_i),
    .irq_o       (irq_o),
    .ld_data_o   (ld_data_o),
    .start_o     (start_o),
    .ld_ctx_o    (ld_ctx_o),
    .cont_o      (cont_o)
);

// File: tb/dma_chan_regs_tb.sv
module dma_chan_regs_tb;

    localparam int NCH = 3;
    localparam int IW  = 4;
    localparam int SW  = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_write = 1'b0;
    logic [15:0]     req_addr = '0;
    logic [3:0]      req_be = '0;
    logic [31:0]     req_wdata = '0;
    logic [31:0]     rdata;
    logic [NCH-1:0]  eol = '0;
    logic [NCH*SW-1:0] src = {4'hA, 4'h5, 4'h1};
    logic [NCH*IW-1:0] iset = '0;
    logic [NCH-1:0]  irq, ld_data, start, ld_ctx, cont;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [31:0] v;
        string       tag;
    } exp_t;
    exp_t expq[$];

    always #4 clk = ~clk;

    dma_chan_regs u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
        .req_be_i(req_be), .req_wdata_i(req_wdata), .rdata_o(rdata),
        .eol_i(eol), .src_i(src), .intr_set_i(iset), .irq_o(irq),
        .ld_data_o(ld_data), .start_o(start), .ld_ctx_o(ld_ctx), .cont_o(cont)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the expected read word one cycle after each read
    always @(negedge clk) begin
        if (expq.size() > 0) begin
            exp_t e;
            e = expq.pop_front();
            chk(rdata, e.v, e.tag);
        end
    end

    task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string tag,
                      input logic [3:0] be = 4'hF);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = be;
        @(posedge clk); #1;
        req_valid = 1'b0;
        e.v = exp; e.tag = tag;
        expq.push_back(e);
    endtask

    function automatic logic [31:0] pulses();
        return 32'({ld_data, start, ld_ctx, cont});
    endfunction

    initial begin
        #1600000;
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk(32'(irq), 0, "R6 reset irq");
        chk(pulses(), 0, "R7 reset pulses");
        rd(16'h0088, 32'h101, "R4 reset status ch0");
        rd(16'h2088, 32'h501, "R4 reset status ch1");

        // R2 storage and channel isolation
        wr(16'h0000, 32'hDEADBEEF);
        wr(16'h2058, 32'h12345678);
        wr(16'h407C, 32'hCAFEF00D);
        wr(16'h205C, 32'h0BADF00D);
        wr(16'h2060, 32'h13579BDF);
        rd(16'h0000, 32'hDEADBEEF, "R2 data ch0");
        rd(16'h2058, 32'h12345678, "R2 sdesc ch1");
        rd(16'h407C, 32'hCAFEF00D, "R2 gdown ch2");
        rd(16'h205C, 32'h0BADF00D, "R2 sbuf ch1");
        rd(16'h2060, 32'h13579BDF, "R2 group ch1");
        rd(16'h0058, 32'h0, "R1 ch0 sdesc untouched");
        rd(16'h2000, 32'h0, "R1 ch1 data untouched");

        // R3 / R4 config and status
        wr(16'h0084, 32'hFFFFFFFF);
        rd(16'h0084, 32'h3, "R2 cfg keeps two bits");
        rd(16'h0088, 32'h102, "R3 stopped");
        @(negedge clk); eol[0] = 1'b1;
        rd(16'h0088, 32'h122, "R4 eol bit");
        @(negedge clk); eol[0] = 1'b0;
        wr(16'h0084, 32'h2);
        rd(16'h0088, 32'h101, "R3 enable clear wins");

        // R7 stream commands
        wr(16'h009C, 32'hFFFFFD60);
        chk(pulses(), 32'({3'b001, 3'b001, 3'b000, 3'b000}), "R7 load+start");
        @(posedge clk); #1;
        chk(pulses(), 0, "R7 single cycle");
        rd(16'h009C, 32'h160, "R2 stream ten bits");
        rd(16'h0088, 32'h104, "R3 running after start");
        wr(16'h409C, 32'h200);
        chk(pulses(), 32'({3'b000, 3'b000, 3'b100, 3'b000}), "R7 ctx load");
        wr(16'h409C, 32'h040);
        chk(pulses(), 32'({3'b100, 3'b000, 3'b000, 3'b000}), "R7 data load no start");
        wr(16'h409C, 32'h020);
        chk(pulses(), 0, "R7 burst alone");
        rd(16'h4088, 32'hA01, "R3 ch2 not started");

        // R8 continue
        wr(16'h2080, 32'h1);
        chk(pulses(), 32'({3'b000, 3'b000, 3'b000, 3'b010}), "R8 continue ch1");
        rd(16'h2080, 32'h1, "R2 cmd readback");

        // R5 / R6 interrupts on ch2
        wr(16'h408C, 32'hFFFFFFF5);
        rd(16'h408C, 32'h5, "R2 mask width");
        @(negedge clk); iset[11:8] = 4'h3;
        @(posedge clk); #1; iset = '0;
        chk(32'(irq), 32'b100, "R6 irq raised");
        rd(16'h4094, 32'h3, "R5 raw set");
        rd(16'h4098, 32'h1, "R6 masked");
        wr(16'h4090, 32'h1);
        chk(32'(irq), 0, "R6 irq after ack");
        rd(16'h4094, 32'h2, "R5 raw after ack");
        rd(16'h4090, 32'h0, "R5 ack reads zero");
        iset[11:8] = 4'h4;
        wr(16'h4090, 32'h4);
        iset = '0;
        chk(32'(irq), 32'b100, "R5 set wins over ack");
        rd(16'h4094, 32'h6, "R5 raw after collision");
        wr(16'h4094, 32'h0);
        rd(16'h4094, 32'h6, "R5 raw write ignored");
        wr(16'h4090, 32'hF);
        rd(16'h4094, 32'h0, "R5 ack all");
        chk(32'(irq), 0, "R6 irq low");

        // R9 narrow and undefined
        wr(16'h0000, 32'h11111111, 4'h3);
        rd(16'h0000, 32'hDEADBEEF, "R9 narrow write ignored");
        rd(16'h0000, 32'h0, "R9 narrow read zero", 4'h1);
        wr(16'h0080, 32'h1, 4'h7);
        chk(pulses(), 0, "R9 narrow cmd no pulse");
        wr(16'h0040, 32'hAAAA5555);
        rd(16'h0040, 32'h0, "R9 undefined reads zero");
        wr(16'h0088, 32'h0);
        rd(16'h0088, 32'h104, "R4 status write ignored");

        // R1 out of range channel
        wr(16'h6000, 32'h55555555);
        wr(16'h6080, 32'h1);
        chk(pulses(), 0, "R1 out of range no pulse");
        rd(16'h6000, 32'h0, "R1 out of range reads zero");
        rd(16'h0000, 32'hDEADBEEF, "R1 no alias ch0");
        rd(16'h4000, 32'h0, "R1 no alias ch2");

        // R10 idle read data
        repeat (3) @(posedge clk);
        #1 chk(rdata, 0, "R10 idle zero");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule